// File: doc/BRIEF.md
# Adapter / Battery Power-Path Selector

This block decides whether the system rail is fed from the external adapter or from the battery pack. It drives two active-low switch enables, one for the adapter path and one for the battery path. Its inputs are digitised comparator flags for adapter presence, input overvoltage, input over-power, supply undervoltage and low battery, plus a learn request from the host. It also reports adapter presence on an active-low status output.

The raw adapter flag is filtered by a long qualification window on its rising side and a short window on its falling side. A qualified adapter is connected unless learn mode asks to run from the battery. Learn mode is dropped while the battery is low. An overvoltage flag opens the adapter switch in the same cycle and does not latch. An over-power trip latches the adapter off until the raw adapter flag goes low or undervoltage lockout asserts. Every change of path passes through a dead interval with both switches open. All delays are parameters in clock cycles.

Top module: `pwr_path_sel`

## Requirements
- R1: While reset is held and directly after it, bat_en_n is 0, adp_en_n is 1, chg_ok is 0 and adp_good_n is 1.
- R2: adp_det must stay high for RISE_CYC consecutive cycles before the adapter is qualified. A shorter high pulse changes no output. After a qualified rise (learn low, no fault), adp_en_n is 0, bat_en_n is 1, chg_ok is 1 and adp_good_n is 0 within RISE_CYC+DEAD_CYC+4 cycles. The battery switch stays closed for at least RISE_CYC-1 cycles.
- R3: With a qualified adapter and learn high (low_bat low), the battery switch is on, the adapter switch is off and chg_ok is 0. adp_good_n stays 0.
- R4: In learn mode, low_bat high returns the path to the adapter. low_bat low moves it back to the battery.
- R5: Without a qualified adapter, bat_en_n is 0 and adp_en_n is 1 for either level of learn.
- R6: adp_en_n and bat_en_n are never 0 together. Each path change holds both at 1 for exactly DEAD_CYC cycles.
- R7: A low gap on adp_det shorter than FALL_CYC cycles is ignored. A low of FALL_CYC cycles or more disqualifies the adapter and moves the load to the battery.
- R8: in_ovp high forces adp_en_n to 1 and chg_ok to 0 in the same cycle. When in_ovp clears, the adapter path returns after a dead interval, with no latching.
- R9: A pwr_trip pulse latches the adapter switch off and the load moves to the battery. The latch clears when raw adp_det goes low or uv_lock asserts. uv_lock also disqualifies the adapter, so it must be qualified again over RISE_CYC cycles.
- R10: adp_good_n returns to 1 GOOD_FALL_CYC cycles after adp_det goes low (not yet after FALL_CYC-1 cycles), and at once on uv_lock.
- R11: A path request that changes during a dead interval is held until the interval ends, and only the newest request is applied. A request that reverses within the interval returns to the original path without closing the other switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adp_det | input | 1 | Raw adapter-present flag |
| in_ovp | input | 1 | Input overvoltage flag |
| pwr_trip | input | 1 | Input over-power trip flag |
| uv_lock | input | 1 | Supply undervoltage lockout |
| low_bat | input | 1 | Battery below low threshold |
| learn | input | 1 | Host request to run from the battery |
| adp_en_n | output | 1 | Adapter switch enable, 0 = on |
| bat_en_n | output | 1 | Battery switch enable, 0 = on |
| chg_ok | output | 1 | Charging permitted |
| adp_good_n | output | 1 | Adapter good status, 0 = good |

## Verification
A wrong selector state shows up at the switch enables. A stuck dead-interval counter shows as both enables high for longer or shorter than DEAD_CYC cycles at the next path change. A lost over-power latch lets the adapter switch close again within one dead interval of the trip. An error in the deglitch counter moves the qualification or the loss of the adapter away from its cycle window. The stimulus therefore samples each edge just inside and just outside its window. It also counts the both-off cycles on every transition it makes.

// File: rtl/pwr_path_sel.sv
module pwr_path_sel #(
  parameter int RISE_CYC      = 64,
  parameter int FALL_CYC      = 8,
  parameter int GOOD_FALL_CYC = 10,
  parameter int DEAD_CYC      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adp_det,
  input  logic in_ovp,
  input  logic pwr_trip,
  input  logic uv_lock,
  input  logic low_bat,
  input  logic learn,
  output logic adp_en_n,
  output logic bat_en_n,
  output logic chg_ok,
  output logic adp_good_n
);
  localparam int CMAX = (RISE_CYC > FALL_CYC) ?
                        ((RISE_CYC > GOOD_FALL_CYC) ? RISE_CYC : GOOD_FALL_CYC) :
                        ((FALL_CYC > GOOD_FALL_CYC) ? FALL_CYC : GOOD_FALL_CYC);
  localparam int CW = $clog2(CMAX + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] C_MAX  = CW'(CMAX);
  localparam logic [CW-1:0] C_RISE = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] C_FALL = CW'(FALL_CYC - 1);
  localparam logic [CW-1:0] C_GOOD = CW'(GOOD_FALL_CYC - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEAD_CYC - 1);

  typedef enum logic [1:0] {ON_BAT, IN_DEAD, ON_ADP} path_t;

  logic          det_s, adp_q, good, trip_lat, want_adp;
  logic [CW-1:0] run_cnt;
  logic [DW-1:0] dead_cnt;
  path_t         st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_s   <= 1'b0;
      run_cnt <= '0;
      adp_q   <= 1'b0;
      good    <= 1'b0;
    end else begin
      det_s <= adp_det;
      if (uv_lock || adp_det != det_s) run_cnt <= '0;
      else if (run_cnt != C_MAX)       run_cnt <= run_cnt + 1'b1;
      if (uv_lock) begin
        adp_q <= 1'b0;
        good  <= 1'b0;
      end else if (det_s && run_cnt == C_RISE) begin
        adp_q <= 1'b1;
        good  <= 1'b1;
      end else begin
        if (!det_s && run_cnt == C_FALL) adp_q <= 1'b0;
        if (!det_s && run_cnt == C_GOOD) good  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  trip_lat <= 1'b0;
    else if (!adp_det || uv_lock) trip_lat <= 1'b0;
    else if (pwr_trip)            trip_lat <= 1'b1;
  end

  assign want_adp = adp_q && !in_ovp && !trip_lat && (!learn || low_bat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ON_BAT;
      dead_cnt <= '0;
    end else begin
      case (st)
        ON_BAT: if (want_adp) begin
          st       <= IN_DEAD;
          dead_cnt <= '0;
        end
        ON_ADP: if (!want_adp) begin
          st       <= IN_DEAD;
          dead_cnt <= '0;
        end
        default: begin
          if (dead_cnt == D_LAST) st <= want_adp ? ON_ADP : ON_BAT;
          else                    dead_cnt <= dead_cnt + 1'b1;
        end
      endcase
    end
  end

  assign adp_en_n   = !(st == ON_ADP && !in_ovp && !trip_lat);
  assign bat_en_n   = !(st == ON_BAT);
  assign chg_ok     = !adp_en_n;
  assign adp_good_n = !good;

  // R6
  never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adp_en_n && !bat_en_n));
  // R6
  bat_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_en_n) |-> $past(adp_en_n));
  // R6
  adp_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adp_en_n) |-> $past(bat_en_n));
  // R8
  ovp_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ovp |-> (adp_en_n && !chg_ok));
  // R9
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lat && adp_det && !uv_lock) |=> adp_en_n);
  // R6
  dead_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IN_DEAD) |-> (dead_cnt <= D_LAST));
endmodule

// File: tb/tb_pwr_path_sel.sv
module tb_pwr_path_sel;
  localparam int RISE = 40, FALL = 9, GF = 12, DEAD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adp_det = 0, in_ovp = 0, pwr_trip = 0, uv_lock = 0, low_bat = 0, learn = 0;
  logic adp_en_n, bat_en_n, chg_ok, adp_good_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pwr_path_sel #(.RISE_CYC(RISE), .FALL_CYC(FALL), .GOOD_FALL_CYC(GF), .DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .adp_det(adp_det), .in_ovp(in_ovp), .pwr_trip(pwr_trip),
    .uv_lock(uv_lock), .low_bat(low_bat), .learn(learn),
    .adp_en_n(adp_en_n), .bat_en_n(bat_en_n), .chg_ok(chg_ok), .adp_good_n(adp_good_n));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_path(input string req, input logic a_n, input logic b_n, input logic c);
    chk(adp_en_n == a_n, req, "adp_en_n", adp_en_n, a_n);
    chk(bat_en_n == b_n, req, "bat_en_n", bat_en_n, b_n);
    chk(chg_ok == c, req, "chg_ok", chg_ok, c);
  endtask

  task automatic measure_gap(input string req, input logic to_adp);
    int gap = 0;
    int guard = 0;
    while ((to_adp ? adp_en_n : bat_en_n) && guard < 100) begin
      if (adp_en_n && bat_en_n) gap++;
      tick(1);
      guard++;
    end
    chk(gap == DEAD, req, "both-off cycles", gap, DEAD);
  endtask

  task automatic t_reset;
    #5 chk_path("R1", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b1, "R1", "adp_good_n in reset", adp_good_n, 1);
    tick(2); rst_n = 1'b1; tick(2);
    chk_path("R1", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b1, "R1", "adp_good_n after reset", adp_good_n, 1);
  endtask

  task automatic t_qualify;
    adp_det = 1; tick(RISE - 5); adp_det = 0; tick(8);
    chk_path("R2", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b1, "R2", "short pulse good", adp_good_n, 1);
    tick(FALL + 4);
    adp_det = 1; tick(RISE - 1);
    chk_path("R2", 1'b1, 1'b0, 1'b0);
    tick(DEAD + 5);
    chk_path("R2", 1'b0, 1'b1, 1'b1);
    chk(adp_good_n == 1'b0, "R2", "adp_good_n", adp_good_n, 0);
  endtask

  task automatic t_learn;
    learn = 1; tick(DEAD + 4);
    chk_path("R3", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b0, "R3", "good in learn", adp_good_n, 0);
    low_bat = 1; tick(DEAD + 4);
    chk_path("R4", 1'b0, 1'b1, 1'b1);
    low_bat = 0; tick(DEAD + 4);
    chk_path("R4", 1'b1, 1'b0, 1'b0);
    learn = 0; tick(DEAD + 4);
    chk_path("R4", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_gap;
    learn = 1; tick(1);
    measure_gap("R6", 1'b0);
    chk_path("R6", 1'b1, 1'b0, 1'b0);
    learn = 0; tick(1);
    measure_gap("R6", 1'b1);
    chk_path("R6", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    int bat_seen = 0;
    learn = 1; tick(3);
    chk(adp_en_n && bat_en_n, "R11", "both off in gap", {adp_en_n, bat_en_n}, 3);
    learn = 0;
    for (int i = 0; i < DEAD + 3; i++) begin
      if (!bat_en_n) bat_seen++;
      tick(1);
    end
    chk(bat_seen == 0, "R11", "battery closed in reversal", bat_seen, 0);
    chk_path("R11", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_fall;
    adp_det = 0; tick(FALL - 3); adp_det = 1; tick(3);
    chk_path("R7", 1'b0, 1'b1, 1'b1);
    adp_det = 0; tick(FALL - 1);
    chk_path("R7", 1'b0, 1'b1, 1'b1);
    chk(adp_good_n == 1'b0, "R10", "good before window", adp_good_n, 0);
    tick(DEAD + 4);
    chk_path("R7", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b1, "R10", "good after loss", adp_good_n, 1);
    learn = 1; tick(3);
    chk_path("R5", 1'b1, 1'b0, 1'b0);
    learn = 0; tick(3);
    chk_path("R5", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ovp;
    adp_det = 1; tick(RISE + DEAD + 4);
    chk_path("R8", 1'b0, 1'b1, 1'b1);
    in_ovp = 1; #2;
    chk_path("R8", 1'b1, 1'b1, 1'b0);
    tick(DEAD + 3);
    chk_path("R8", 1'b1, 1'b0, 1'b0);
    in_ovp = 0; tick(DEAD + 4);
    chk_path("R8", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_trip;
    pwr_trip = 1; tick(1); pwr_trip = 0; tick(DEAD + 4);
    chk_path("R9", 1'b1, 1'b0, 1'b0);
    tick(20);
    chk_path("R9", 1'b1, 1'b0, 1'b0);
    adp_det = 0; tick(2); adp_det = 1; tick(DEAD + 4);
    chk_path("R9", 1'b0, 1'b1, 1'b1);
    pwr_trip = 1; tick(1); pwr_trip = 0; tick(2);
    uv_lock = 1; tick(1); uv_lock = 0; tick(DEAD + 4);
    chk_path("R9", 1'b1, 1'b0, 1'b0);
    chk(adp_good_n == 1'b1, "R10", "good after lockout", adp_good_n, 1);
    tick(RISE - 12);
    chk_path("R9", 1'b1, 1'b0, 1'b0);
    tick(12);
    chk_path("R9", 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_learn();
    t_gap();
    t_hold();
    t_fall();
    t_ovp();
    t_trip();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule